// File: doc/BRIEF.md
# Start-Character Autobaud Detector

This block recovers a serial sender's bit rate from the timing of a known sync character, the value 0x0F, sent at the head of every packet. It watches the raw receive line, times the interval between two falling edges of that character, and turns the interval into the divisor for a baud generator that oversamples each bit by a fixed factor (16 by default). A new divisor is announced with a single-cycle strobe.

The packet receiver owns the `arm` input. It holds `arm` high while it is idle and waiting for a packet, and drops it once a packet is under way. This lets the detector measure once at the start of each packet, so the link follows the sender's rate from packet to packet. Sync characters that arrive inside a packet are never measured. If a measurement takes too long, it is thrown away and the previous divisor stays in force.

Top module: `autobaud_detect`

## Requirements
- R1: While `rst_n` is low, and in the cycle that follows its release, `divisor` equals the parameter `INIT_DIV` and `div_done` is low.
- R2: The line idles high and carries the character least significant bit first, as follows. There is one low start bit, then four high bits, then four low bits, then a high stop bit. A measurement starts at a falling edge of `rx_line` seen while armed. It ends at the next falling edge that follows a rising edge. For the sync character this interval is five bit times.
- R3: With N the measured interval in clocks and U = `OVERSAMPLE`·`SPAN_BITS`, the new divisor is floor((N + floor(U/2)) / U) − 1. This is the nearest integer, with halves rounded up, so a bit time of `OVERSAMPLE`·(X+1) clocks yields X.
- R4: A result below 0 is clamped to 0, and a result above 2^`DIV_W`−1 is clamped to 2^`DIV_W`−1.
- R5: `div_done` is high for exactly one cycle, the first cycle in which the new `divisor` is visible. This is two clock edges after the ending edge is sampled past the synchronizer. `divisor` never changes in a cycle where `div_done` is low.
- R6: A sync character sent while `arm` is low produces no `div_done` and leaves `divisor` unchanged.
- R7: After a result, further sync characters are ignored until `arm` has gone low and then high again.
- R8: A measurement whose interval N exceeds `TIMEOUT_CYCLES` is discarded, with no `div_done` and `divisor` unchanged. An interval of exactly `TIMEOUT_CYCLES` is accepted.
- R9: If `arm` falls while a measurement is running, the measurement is abandoned without a result.
- R10: Each new arm period measures afresh, so successive packets at different rates each produce their own divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rx_line | input | 1 | Raw asynchronous serial receive line, idle high |
| arm | input | 1 | High while the packet receiver is idle and a sync measurement is allowed |
| divisor | output | DIV_W (8) | Current baud generator divisor |
| div_done | output | 1 | One-cycle strobe marking a newly written divisor |

## Verification
The bench builds the detector with `OVERSAMPLE`=4, `DIV_W`=4, `TIMEOUT_CYCLES`=420 and `INIT_DIV`=9, so that one measurement unit is 20 clocks. With these values the bench can sweep every integer bit time from 1 to 80 clocks, and the expected divisor for each one is computed arithmetically. The sweep passes through the clamp at zero, every rounding step, and the clamp at the top of the narrow divisor. The small timeout puts both sides of the rejection limit (bit times 84 and 85) within a few hundred cycles. It also lets the bench test mid-packet suppression, the single result per arm period, and abandonment when arm drops during a measurement.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

   // Measurement controller states.
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // waiting for a start edge while armed
      ST_LOW  = 2'd1,   // start bit seen, waiting for the line to rise
      ST_HIGH = 2'd2,   // high data bits seen, waiting for the closing fall
      ST_HOLD = 2'd3    // result delivered, waiting for arm to drop
   } ab_state_t;

   // Bits needed to hold values 0 .. n-1 (at least one bit).
   function automatic int bits_for(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ab_line_sync.sv
module ab_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic fall,
   output logic rise
);

   if (STAGES < 0 || STAGES > 8) begin : g_bad_stages
      $error("ab_line_sync: STAGES must lie in 0..8");
   end

   logic line_r;
   logic line_q;

   // Variant choice: direct feed or a metastability chain.
   if (STAGES == 0) begin : g_direct
      assign line_r = line_in;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '1;
         end else begin
            chain[0] <= line_in;
            for (int i = 1; i < STAGES; i++) begin
               chain[i] <= chain[i-1];
            end
         end
      end
      assign line_r = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b1;
      else        line_q <= line_r;
   end

   assign fall = line_q & ~line_r;
   assign rise = ~line_q & line_r;

   // An edge report of one kind excludes the other.
   assert_edge_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall && rise));

   // Two falls cannot be back to back without a rise in between.
   assert_fall_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/ab_span_meter.sv
module ab_span_meter #(
   parameter int UNIT    = 80,
   parameter int TIMEOUT = 24000,
   parameter int Q_W     = 10,
   parameter int Q_SAT   = 257
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           run,
   output logic [Q_W-1:0] quo_now,
   output logic           expired
);

   localparam int SUB_W = autobaud_pkg::bits_for(UNIT);
   localparam int EL_W  = autobaud_pkg::bits_for(TIMEOUT + 1);
   localparam int HALF  = UNIT / 2;

   if (UNIT < 1) begin : g_bad_unit
      $error("ab_span_meter: UNIT must be at least 1");
   end
   if (TIMEOUT < UNIT) begin : g_bad_timeout
      $error("ab_span_meter: TIMEOUT must cover at least one UNIT");
   end
   if (Q_SAT >= (1 << Q_W)) begin : g_bad_qsat
      $error("ab_span_meter: Q_SAT does not fit in Q_W bits");
   end

   logic [SUB_W-1:0] sub_q;
   logic [Q_W-1:0]   quo_q;
   logic [EL_W-1:0]  el_q;
   logic             wrap;

   // Rounding prescaler: starting the phase at UNIT/2 makes the quotient
   // equal floor((n + UNIT/2) / UNIT) after n counted clocks.
   assign wrap    = (sub_q == SUB_W'(UNIT - 1));
   assign quo_now = (wrap && quo_q != Q_W'(Q_SAT)) ? quo_q + Q_W'(1) : quo_q;
   assign expired = run && (el_q == EL_W'(TIMEOUT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         quo_q <= '0;
         el_q  <= '0;
      end else if (clear) begin
         sub_q <= SUB_W'(HALF);
         quo_q <= '0;
         el_q  <= '0;
      end else if (run) begin
         sub_q <= wrap ? '0 : sub_q + SUB_W'(1);
         quo_q <= quo_now;
         if (el_q != EL_W'(TIMEOUT)) el_q <= el_q + EL_W'(1);
      end
   end

   // A fresh measurement starts from an empty quotient and elapsed count.
   assert_clear_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (quo_q == '0 && el_q == '0));

   // The quotient advances by at most one step per counted clock.
   assert_quo_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear) |=> (quo_q == $past(quo_q) || quo_q == $past(quo_q) + Q_W'(1)));

   // The elapsed count never passes the timeout limit.
   assert_elapsed_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear) |=> (el_q <= EL_W'(TIMEOUT)));

endmodule

// File: rtl/ab_div_map.sv
module ab_div_map #(
   parameter int DIV_W = 8,
   parameter int Q_W   = 10
) (
   input  logic [Q_W-1:0]   quo,
   output logic [DIV_W-1:0] div
);

   localparam int DIV_TOP = (1 << DIV_W) - 1;

   if (Q_W < DIV_W + 1) begin : g_bad_qw
      $error("ab_div_map: Q_W must exceed DIV_W");
   end

   // Subtract one from the rounded span count and clamp to the divisor range.
   always_comb begin
      if (quo == '0) begin
         div = '0;
      end else if (quo > Q_W'(DIV_TOP + 1)) begin
         div = DIV_W'(DIV_TOP);
      end else begin
         div = DIV_W'(quo - Q_W'(1));
      end
   end

endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect #(
   parameter int              DIV_W          = 8,
   parameter int              OVERSAMPLE     = 16,
   parameter int              SPAN_BITS      = 5,
   parameter int              TIMEOUT_CYCLES = 24000,
   parameter int              SYNC_STAGES    = 2,
   parameter logic [DIV_W-1:0] INIT_DIV      = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_line,
   input  logic             arm,
   output logic [DIV_W-1:0] divisor,
   output logic             div_done
);

   import autobaud_pkg::*;

   localparam int UNIT  = OVERSAMPLE * SPAN_BITS;
   localparam int Q_SAT = (1 << DIV_W) + 1;
   localparam int Q_W   = DIV_W + 2;

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_divw
      $error("autobaud_detect: DIV_W must lie in 1..16");
   end
   if (OVERSAMPLE < 1 || SPAN_BITS < 1) begin : g_bad_unit
      $error("autobaud_detect: OVERSAMPLE and SPAN_BITS must be positive");
   end

   logic            fall;
   logic            rise;
   logic            meas_clear;
   logic            meas_run;
   logic            expired;
   logic            end_hit;
   logic [Q_W-1:0]  quo_now;
   logic [DIV_W-1:0] div_map;
   ab_state_t       state;
   ab_state_t       state_nx;

   ab_line_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (rx_line),
      .fall    (fall),
      .rise    (rise)
   );

   ab_span_meter #(
      .UNIT    (UNIT),
      .TIMEOUT (TIMEOUT_CYCLES),
      .Q_W     (Q_W),
      .Q_SAT   (Q_SAT)
   ) i_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (meas_clear),
      .run     (meas_run),
      .quo_now (quo_now),
      .expired (expired)
   );

   ab_div_map #(
      .DIV_W (DIV_W),
      .Q_W   (Q_W)
   ) i_map (
      .quo (quo_now),
      .div (div_map)
   );

   assign meas_clear = (state == ST_IDLE) && arm && fall;
   assign meas_run   = (state == ST_LOW) || (state == ST_HIGH);
   assign end_hit    = (state == ST_HIGH) && arm && fall && !expired;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (arm && fall) state_nx = ST_LOW;
         ST_LOW: begin
            if (!arm || expired) state_nx = ST_IDLE;
            else if (rise)       state_nx = ST_HIGH;
         end
         ST_HIGH: begin
            if (!arm || expired) state_nx = ST_IDLE;
            else if (fall)       state_nx = ST_HOLD;
         end
         ST_HOLD: if (!arm) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         divisor  <= INIT_DIV;
         div_done <= 1'b0;
      end else begin
         state    <= state_nx;
         div_done <= end_hit;
         if (end_hit) divisor <= div_map;
      end
   end

   // The completion strobe lasts a single cycle.
   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |=> !div_done);

   // The divisor moves only together with the strobe.
   assert_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !div_done |-> $stable(divisor));

   // With arm low the controller returns to waiting and cannot be measuring.
   assert_unarmed_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> (state == ST_IDLE));

   // Once a result is out, a held arm blocks further results.
   assert_hold_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && arm) |=> !div_done);

   // An expired measurement yields no result.
   assert_expire_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_run && expired) |=> !div_done);

   // A measurement interrupted by arm falling yields no result.
   assert_abort_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_run && !arm) |=> !div_done);

endmodule

// File: tb/test_autobaud_detect.sv
`timescale 1ns/1ps
module test_autobaud_detect;

   localparam int DIV_W   = 4;
   localparam int OS      = 4;
   localparam int SPAN    = 5;
   localparam int TMO     = 420;
   localparam int UNIT    = OS * SPAN;
   localparam int DIV_TOP = (1 << DIV_W) - 1;
   localparam logic [DIV_W-1:0] INIT = 4'd9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_line = 1'b1;
   logic             arm = 1'b0;
   logic [DIV_W-1:0] divisor;
   logic             div_done;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   autobaud_detect #(
      .DIV_W          (DIV_W),
      .OVERSAMPLE     (OS),
      .SPAN_BITS      (SPAN),
      .TIMEOUT_CYCLES (TMO),
      .SYNC_STAGES    (2),
      .INIT_DIV       (INIT)
   ) i_autobaud_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_line  (rx_line),
      .arm      (arm),
      .divisor  (divisor),
      .div_done (div_done)
   );

   always @(posedge clk) if (div_done) done_cnt <= done_cnt + 1;

   // Expected divisor for a bit time of t clocks (R3, R4).
   function automatic int exp_div(input int t);
      int q;
      q = (SPAN * t + UNIT / 2) / UNIT;
      if (q == 0) return 0;
      if (q - 1 > DIV_TOP) return DIV_TOP;
      return q - 1;
   endfunction

   task automatic check(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Sends one character LSB first with start and stop bits, t clocks per bit.
   task automatic send_byte(input logic [7:0] b, input int t);
      rx_line = 1'b0;
      tick(t);
      for (int i = 0; i < 8; i++) begin
         rx_line = b[i];
         tick(t);
      end
      rx_line = 1'b1;
      tick(t);
   endtask

   task automatic rearm();
      arm = 1'b0;
      tick(3);
      arm = 1'b1;
      tick(3);
   endtask

   initial begin
      int base;
      int held;
      tick(4);
      // R1: values during reset.
      check("R1", "divisor in reset", int'(divisor), int'(INIT));
      check("R1", "done in reset", int'(div_done), 0);
      rst_n = 1'b1;
      tick(1);
      check("R1", "divisor after release", int'(divisor), int'(INIT));
      check("R1", "done after release", int'(div_done), 0);

      // R6: sync character while the receiver is busy.
      base = done_cnt;
      send_byte(8'h0F, 10);
      tick(4);
      check("R6", "strobes while unarmed", done_cnt - base, 0);
      check("R6", "divisor while unarmed", int'(divisor), int'(INIT));

      // R2 R3 R4 R10: sweep every bit time, one packet each.
      for (int t = 1; t <= 80; t++) begin
         rearm();
         base = done_cnt;
         send_byte(8'h0F, t);
         tick(4);
         check("R10", $sformatf("strobes at bit time %0d", t), done_cnt - base, 1);
         check("R3", $sformatf("divisor at bit time %0d", t), int'(divisor), exp_div(t));
      end

      // R7: a second sync character in the same arm period is ignored.
      rearm();
      base = done_cnt;
      send_byte(8'h0F, 12);
      tick(4);
      check("R7", "first result", int'(divisor), exp_div(12));
      send_byte(8'h0F, 30);
      tick(4);
      check("R7", "strobes in one arm period", done_cnt - base, 1);
      check("R7", "divisor kept", int'(divisor), exp_div(12));

      // R8: just past the timeout is rejected.
      held = int'(divisor);
      rearm();
      base = done_cnt;
      send_byte(8'h0F, 85);
      tick(4);
      check("R8", "strobes past timeout", done_cnt - base, 0);
      check("R8", "divisor past timeout", int'(divisor), held);

      // R8 R4: exactly at the timeout is accepted and clamps high.
      rearm();
      base = done_cnt;
      send_byte(8'h0F, 84);
      tick(4);
      check("R8", "strobes at timeout", done_cnt - base, 1);
      check("R4", "clamped divisor", int'(divisor), DIV_TOP);

      // R8: a far slower sender is also rejected.
      rearm();
      base = done_cnt;
      send_byte(8'h0F, 100);
      tick(4);
      check("R8", "strobes slow sender", done_cnt - base, 0);
      check("R8", "divisor slow sender", int'(divisor), DIV_TOP);

      // R9: arm drops in the middle of a measurement.
      rearm();
      base = done_cnt;
      fork
         send_byte(8'h0F, 40);
         begin
            tick(100);
            arm = 1'b0;
         end
      join
      tick(4);
      check("R9", "strobes after abort", done_cnt - base, 0);
      check("R9", "divisor after abort", int'(divisor), DIV_TOP);

      // R10: a following packet still measures.
      rearm();
      base = done_cnt;
      send_byte(8'h0F, 8);
      tick(4);
      check("R10", "strobes after abort", done_cnt - base, 1);
      check("R10", "divisor after abort", int'(divisor), exp_div(8));

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule